// File: doc/BRIEF.md
# Module Clock Enable/Disable Sequencer

This block turns a single enable or disable request for one peripheral module into the sequence of steps on that module's clock-control register. On enable it first asks the parent clock domain for its clock. Once the domain grants it, the block reads the control register, merges the configured mode value into the two low bits and writes the result back. It then keeps reading the register until the module's two-bit idle-status field says the module is usable, or until the enable timeout runs out.

On disable it reads the register, clears the mode bits and writes it back. It then polls until the module reports fully disabled, or until the disable timeout runs out. Only after that does it release the clock domain. Each sequence ends with a one-cycle `done` pulse, with `err` raised in the same cycle if the domain refused or a wait timed out. `is_enabled` reflects the mode bits of the most recent register contents the block saw.

Timeouts are measured in microseconds, and a cycles-per-microsecond parameter converts them to clock cycles. The register port is a plain request/acknowledge port: a request is held until acknowledged, and read data is taken in the acknowledge cycle.

Top module: `modclk_seq`

## Requirements
- R1: Both sequences use read-modify-write on the control register. The write data equals the read data with bits [1:0] replaced: by the configured mode value on enable (1 = hardware-controlled, 2 = software-controlled), or by 0 on disable. Every other bit is written back unchanged.
- R2: On enable, `dom_req` is held until `dom_grant` or `dom_fail`. No register access happens before the grant. A failure ends the sequence with `err` and no register write and no domain release.
- R3: After the enable write, the block polls the status field at bits [17:16]. It finishes without error as soon as a read returns 0 (functional) or 2 (interface idle).
- R4: After the disable write, the block polls until the status field reads 3 (disabled). It then pulses `dom_rel` for one cycle, and `done` follows in the next cycle.
- R5: If the enable poll does not see a ready status within EN_TMO_US × CYC_PER_US cycles, the sequence ends with `err`. The mode write stays in place.
- R6: If the disable poll does not see status 3 within DIS_TMO_US × CYC_PER_US cycles, the sequence ends with `err`. The domain is still released first.
- R7: When `cfg_no_status` is set, no polling read is made. An enable finishes right after its write, and a disable releases the domain right after its write.
- R8: When `cfg_mode` is 0, a request produces `done` in the next cycle. It makes no register access and no domain request or release.
- R9: `is_enabled` is high when any bit set in `cfg_mode` is also set in bits [1:0] of the last register value read or written.
- R10: Requests are taken only while idle, and a request that arrives during a sequence is dropped. `done` is a one-cycle pulse, and `err` is high only together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_en | input | 1 | Start an enable sequence (taken when idle, wins over req_dis) |
| req_dis | input | 1 | Start a disable sequence (taken when idle) |
| cfg_mode | input | 2 | Mode value written on enable; 0 makes requests no-ops |
| cfg_no_status | input | 1 | Module has no idle status; skip polling |
| dom_req | output | 1 | Clock-domain request, held until grant or fail |
| dom_grant | input | 1 | Domain granted |
| dom_fail | input | 1 | Domain request refused |
| dom_rel | output | 1 | One-cycle domain release pulse |
| reg_req | output | 1 | Register access request, held until acknowledged |
| reg_we | output | 1 | 1 = write, 0 = read |
| reg_wdata | output | DATA_W | Register write data |
| reg_rdata | input | DATA_W | Register read data, valid with reg_ack |
| reg_ack | input | 1 | Register access acknowledge |
| done | output | 1 | One-cycle end-of-sequence pulse |
| err | output | 1 | Error, valid with done |
| is_enabled | output | 1 | Mode bits present in last seen register value |

## Verification
With a register port that acknowledges in the same cycle and a domain that answers at once, `done` is due a fixed number of cycles after the request edge. These counts are: 5 for a polled enable or disable that sees the wanted status on the first read, 4 with polling skipped, 2 for a refused domain and 1 for a zero mode. The timeout cases land within a few cycles of the configured limit. The driver pushes the expected error flag, mode bits, write and release counts and a latency window into a queue. The monitor samples on the falling edge, measures the cycles since the request, and compares on each `done` pulse. A `done` that arrives with nothing queued is reported, which is how dropped requests are checked.

// File: rtl/modclk_pkg.sv
// Shared definitions for the module clock sequencer.
// Assumes the mode field sits at bits [1:0] and idle status at [17:16].
package modclk_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_DOM,
        S_RD,
        S_WR,
        S_POLL,
        S_REL,
        S_DONE
    } seq_state_t;

    localparam int MODE_W     = 2;
    localparam int STAT_LSB   = 16;
    localparam int STAT_W     = 2;
    localparam logic [1:0] ST_FUNC  = 2'd0;
    localparam logic [1:0] ST_IFIDL = 2'd2;
    localparam logic [1:0] ST_OFF   = 2'd3;
endpackage

// File: rtl/modclk_status_dec.sv
// Decodes the idle-status field of a control register word.
// Assumes the field position given in modclk_pkg; purely combinational.
module modclk_status_dec
    import modclk_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] word,
    output logic              is_ready,
    output logic              is_off
);
    logic [STAT_W-1:0] st;

    // Extract the field and classify it.
    always_comb begin
        st       = word[STAT_LSB +: STAT_W];
        is_ready = (st == ST_FUNC) || (st == ST_IFIDL);
        is_off   = (st == ST_OFF);
    end
endmodule

// File: rtl/modclk_rmw.sv
// Merge step of the read-modify-write: replaces the mode field of the
// read word with the new value (or zero) and keeps every other bit.
module modclk_rmw
    import modclk_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] old_word,
    input  logic [MODE_W-1:0] mode,
    input  logic              set_mode,
    output logic [DATA_W-1:0] new_word
);
    // Keep upper bits, place mode or zero in the low field.
    always_comb begin
        new_word = old_word;
        new_word[MODE_W-1:0] = set_mode ? mode : '0;
    end
endmodule

// File: rtl/modclk_timer.sv
// Poll timeout timer. A prescaler divides the clock to microsecond ticks;
// a saturating counter of ticks is compared to the enable or disable limit.
// Assumes run stays high for the whole poll and drops between sequences.
module modclk_timer #(
    parameter int CYC_PER_US = 100,
    parameter int EN_TMO_US  = 2000,
    parameter int DIS_TMO_US = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic sel_en,
    output logic expired
);
    localparam int MAX_US = (EN_TMO_US > DIS_TMO_US) ? EN_TMO_US : DIS_TMO_US;
    localparam int UW     = $clog2(MAX_US + 1);
    localparam int PW     = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(CYC_PER_US - 1);

    logic [PW-1:0] pre;
    logic [UW-1:0] us_cnt;
    logic [UW-1:0] limit;

    // Pick the limit for the running direction.
    always_comb limit = sel_en ? UW'(EN_TMO_US) : UW'(DIS_TMO_US);

    // Count microseconds while running; clear otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pre    <= '0;
            us_cnt <= '0;
        end else if (pre == PRE_LAST) begin
            pre <= '0;
            if (us_cnt < limit) us_cnt <= us_cnt + 1'b1;
        end else begin
            pre <= pre + 1'b1;
        end
    end

    // Limit reached.
    always_comb expired = run && (us_cnt >= limit);
endmodule

// File: rtl/modclk_seq.sv
// Module clock enable/disable sequencer (top).
// Enable: domain request -> read -> write mode -> poll ready -> done.
// Disable: read -> clear mode -> poll off -> release domain -> done.
// Assumes cfg_* inputs are stable while a sequence runs.
module modclk_seq
    import modclk_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int CYC_PER_US = 100,
    parameter int EN_TMO_US  = 2000,
    parameter int DIS_TMO_US = 5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_en,
    input  logic              req_dis,
    input  logic [1:0]        cfg_mode,
    input  logic              cfg_no_status,
    output logic              dom_req,
    input  logic              dom_grant,
    input  logic              dom_fail,
    output logic              dom_rel,
    output logic              reg_req,
    output logic              reg_we,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata,
    input  logic              reg_ack,
    output logic              done,
    output logic              err,
    output logic              is_enabled
);
    seq_state_t        state;
    logic              op_en;
    logic              err_q;
    logic [DATA_W-1:0] wr_val;
    logic [DATA_W-1:0] merged;
    logic [DATA_W-1:0] shadow;
    logic              st_ready;
    logic              st_off;
    logic              tmo;
    logic              poll_ok;
    seq_state_t        after_wait;

    modclk_rmw #(.DATA_W(DATA_W)) u_rmw (
        .old_word (reg_rdata),
        .mode     (cfg_mode),
        .set_mode (op_en),
        .new_word (merged)
    );

    modclk_status_dec #(.DATA_W(DATA_W)) u_dec (
        .word     (reg_rdata),
        .is_ready (st_ready),
        .is_off   (st_off)
    );

    modclk_timer #(
        .CYC_PER_US (CYC_PER_US),
        .EN_TMO_US  (EN_TMO_US),
        .DIS_TMO_US (DIS_TMO_US)
    ) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state == S_POLL),
        .sel_en  (op_en),
        .expired (tmo)
    );

    // Status wanted by the current direction, and where waits end.
    always_comb begin
        poll_ok    = op_en ? st_ready : st_off;
        after_wait = op_en ? S_DONE : S_REL;
    end

    // Sequence state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            op_en  <= 1'b0;
            err_q  <= 1'b0;
            wr_val <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    err_q <= 1'b0;
                    if (req_en || req_dis) begin
                        op_en <= req_en;
                        if (cfg_mode == 2'd0) state <= S_DONE;
                        else if (req_en)      state <= S_DOM;
                        else                  state <= S_RD;
                    end
                end
                S_DOM: begin
                    if (dom_grant) begin
                        state <= S_RD;
                    end else if (dom_fail) begin
                        err_q <= 1'b1;
                        state <= S_DONE;
                    end
                end
                S_RD: begin
                    if (reg_ack) begin
                        wr_val <= merged;
                        state  <= S_WR;
                    end
                end
                S_WR: begin
                    if (reg_ack) state <= cfg_no_status ? after_wait : S_POLL;
                end
                S_POLL: begin
                    if (reg_ack) begin
                        if (poll_ok) begin
                            state <= after_wait;
                        end else if (tmo) begin
                            err_q <= 1'b1;
                            state <= after_wait;
                        end
                    end
                end
                S_REL:   state <= S_DONE;
                S_DONE:  state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // Track the last register contents seen on the port.
    always_ff @(posedge clk) begin
        if (!rst_n)                  shadow <= '0;
        else if (reg_req && reg_ack) shadow <= reg_we ? reg_wdata : reg_rdata;
    end

    // Output decode.
    always_comb begin
        dom_req    = (state == S_DOM);
        dom_rel    = (state == S_REL);
        reg_req    = (state == S_RD) || (state == S_WR) || (state == S_POLL);
        reg_we     = (state == S_WR);
        reg_wdata  = wr_val;
        done       = (state == S_DONE);
        err        = (state == S_DONE) && err_q;
        is_enabled = |(shadow[1:0] & cfg_mode);
    end
endmodule

// File: rtl/modclk_seq_chk.sv
// Port-level protocol checks for modclk_seq, attached by bind.
module modclk_seq_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        cfg_mode,
    input logic              dom_req,
    input logic              dom_grant,
    input logic              dom_fail,
    input logic              dom_rel,
    input logic              reg_req,
    input logic              reg_we,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              done,
    input logic              err
);
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_err_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    assert_no_access_in_dom_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dom_req |-> !reg_req);

    assert_fail_aborts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dom_req && dom_fail && !dom_grant) |=> (!reg_req && done && err));

    assert_write_mode_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && reg_we) |-> (reg_wdata[1:0] == 2'd0 || reg_wdata[1:0] == cfg_mode));

    assert_release_then_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dom_rel |=> (done && !dom_rel));
endmodule

bind modclk_seq modclk_seq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_mode  (cfg_mode),
    .dom_req   (dom_req),
    .dom_grant (dom_grant),
    .dom_fail  (dom_fail),
    .dom_rel   (dom_rel),
    .reg_req   (reg_req),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .done      (done),
    .err       (err)
);

// File: tb/modclk_seq_tb.sv
// Scoreboard bench: driver queues expectations, monitor checks each done.
module modclk_seq_tb;
    localparam int DW = 32;
    localparam logic [DW-1:0] INIT = 32'hC3A5_5AF0;
    localparam logic [DW-1:0] KEEP = ~32'h0003_0003;

    typedef struct {
        bit       e_err;
        bit [1:0] e_mode;
        int       e_wr;
        int       e_rel;
        int       lat_lo;
        int       lat_hi;
        bit       chk_en;
        bit       e_en;
        string    tag;
    } exp_t;

    logic clk = 0, rst_n = 0;
    logic req_en = 0, req_dis = 0;
    logic [1:0] cfg_mode = 0;
    logic cfg_no_status = 0;
    logic dom_req, dom_grant, dom_fail, dom_rel;
    logic reg_req, reg_we, reg_ack;
    logic [DW-1:0] reg_wdata, reg_rdata;
    logic done, err, is_enabled;

    logic [DW-1:0] mem;
    logic [1:0] status = 0;
    bit grant_ok = 1;
    int cyc = 0, t0 = 0, wr_cnt = 0, rel_cnt = 0, ops_done = 0;
    int tests = 0, fails = 0;
    exp_t q[$];

    always #5 clk = ~clk;

    modclk_seq #(.DATA_W(DW), .CYC_PER_US(2), .EN_TMO_US(20), .DIS_TMO_US(30)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_en(req_en), .req_dis(req_dis),
        .cfg_mode(cfg_mode), .cfg_no_status(cfg_no_status),
        .dom_req(dom_req), .dom_grant(dom_grant), .dom_fail(dom_fail), .dom_rel(dom_rel),
        .reg_req(reg_req), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reg_ack(reg_ack),
        .done(done), .err(err), .is_enabled(is_enabled)
    );

    // Register and domain models.
    assign reg_ack   = reg_req;
    assign reg_rdata = {mem[31:18], status, mem[15:0]};
    assign dom_grant = dom_req && grant_ok;
    assign dom_fail  = dom_req && !grant_ok;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) mem <= INIT;
        else if (reg_req && reg_we) begin
            mem <= reg_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (dom_rel) rel_cnt <= rel_cnt + 1;
    end

    task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Monitor: compare each done against the queued expectation.
    always @(negedge clk) begin
        if (rst_n && done) begin
            int lat;
            exp_t e;
            lat = cyc - t0;
            if (q.size() == 0) begin
                check(0, "R10", "unexpected done", 1, 0);
            end else begin
                e = q.pop_front();
                check(err == e.e_err, e.tag, "err", int'(err), int'(e.e_err));
                check(mem[1:0] == e.e_mode, e.tag, "mode bits", int'(mem[1:0]), int'(e.e_mode));
                check((mem & KEEP) == (INIT & KEEP), "R1", "kept bits", int'(mem[31:18]), int'(INIT[31:18]));
                check(wr_cnt == e.e_wr, e.tag, "writes", wr_cnt, e.e_wr);
                check(rel_cnt == e.e_rel, e.tag, "releases", rel_cnt, e.e_rel);
                check(lat >= e.lat_lo && lat <= e.lat_hi, e.tag, "latency", lat, e.lat_lo);
                if (e.chk_en) check(is_enabled == e.e_en, "R9", "is_enabled", int'(is_enabled), int'(e.e_en));
            end
            ops_done++;
        end
    end

    // Driver: configure, queue the expectation, pulse a request, wait for done.
    task automatic run_op(input bit en, input logic [1:0] mode, input bit nost,
                          input logic [1:0] st, input bit gok, input exp_t e);
        int n;
        @(negedge clk);
        cfg_mode = mode; cfg_no_status = nost; status = st; grant_ok = gok;
        wr_cnt = 0; rel_cnt = 0;
        q.push_back(e);
        n = ops_done;
        if (en) req_en = 1; else req_dis = 1;
        t0 = cyc;
        @(negedge clk);
        req_en = 0; req_dis = 0;
        wait (ops_done == n + 1);
    endtask

    function automatic exp_t mk(bit er, bit [1:0] md, int w, int r, int lo, int hi,
                                bit ce, bit en_v, string tag);
        exp_t e;
        e.e_err = er; e.e_mode = md; e.e_wr = w; e.e_rel = r;
        e.lat_lo = lo; e.lat_hi = hi; e.chk_en = ce; e.e_en = en_v; e.tag = tag;
        return e;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(!done && !err && !dom_req && !reg_req && !dom_rel && !is_enabled,
              "R10", "reset outputs", int'(done | reg_req | dom_req), 0);

        // R3: software mode enable, status functional
        run_op(1, 2'd2, 0, 2'd0, 1, mk(0, 2'd2, 1, 0, 5, 5, 1, 1, "R3"));
        // R4: disable, status already off
        run_op(0, 2'd2, 0, 2'd3, 1, mk(0, 2'd0, 1, 1, 5, 5, 1, 0, "R4"));
        // R3: hardware mode enable, status interface idle
        run_op(1, 2'd1, 0, 2'd2, 1, mk(0, 2'd1, 1, 0, 5, 5, 1, 1, "R3"));
        // R4: disable with status turning off mid-poll
        fork
            begin
                repeat (9) @(negedge clk);
                status = 2'd3;
            end
        join_none
        run_op(0, 2'd1, 0, 2'd0, 1, mk(0, 2'd0, 1, 1, 7, 14, 0, 0, "R4"));
        // R2: domain refused
        run_op(1, 2'd2, 0, 2'd0, 0, mk(1, 2'd0, 0, 0, 2, 2, 1, 0, "R2"));
        // R7: no-status enable, status never ready
        run_op(1, 2'd2, 1, 2'd3, 1, mk(0, 2'd2, 1, 0, 4, 4, 1, 1, "R7"));
        // R7: no-status disable, status never off
        run_op(0, 2'd2, 1, 2'd0, 1, mk(0, 2'd0, 1, 1, 4, 4, 1, 0, "R7"));
        // R8: zero mode, both directions
        run_op(1, 2'd0, 0, 2'd3, 1, mk(0, 2'd0, 0, 0, 1, 1, 0, 0, "R8"));
        run_op(0, 2'd0, 0, 2'd0, 1, mk(0, 2'd0, 0, 0, 1, 1, 0, 0, "R8"));
        // R5: enable timeout (40 cycles of polling)
        run_op(1, 2'd2, 0, 2'd3, 1, mk(1, 2'd2, 1, 0, 43, 48, 0, 0, "R5"));
        // R6: disable timeout (60 cycles of polling), still released
        run_op(0, 2'd2, 0, 2'd2, 1, mk(1, 2'd0, 1, 1, 62, 68, 0, 0, "R6"));
        // R10: a disable request during an enable is dropped
        fork
            begin
                repeat (3) @(negedge clk);
                req_dis = 1;
                @(negedge clk);
                req_dis = 0;
            end
        join_none
        run_op(1, 2'd2, 0, 2'd0, 1, mk(0, 2'd2, 1, 0, 5, 5, 1, 1, "R10"));
        repeat (12) @(negedge clk);
        check(mem[1:0] == 2'd2, "R10", "mode after dropped request", int'(mem[1:0]), 2);
        check(rel_cnt == 0, "R10", "no release from dropped request", rel_cnt, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule